// File: doc/BRIEF.md
# Shift and Rotate Unit with Condition Flags

This block is the shift and rotate stage of a 32-bit processor datapath. It is purely combinational. It takes a 32-bit operand, an 8-bit shift amount and a 3-bit operation code. From these it produces the shifted or rotated result and the new negative, zero, carry and overflow flags, all within the same cycle.

The amount port carries either an immediate field or the low byte of a register, so any value from 0 to 255 can arrive. The valid immediate ranges form a subset of that span, and they behave the same way as the matching register values. Amount 0 with a left shift is therefore a plain move. An immediate of 32 with a right shift means a full-width shift.

Every amount of 32 or more has a defined result and carry. One operation rotates right by exactly one place through the carry flag. When flag setting is off, all four flags leave the block unchanged.

Top module: `shift_rotate_unit`

## Requirements
- R1: With op_sel 0 (logical left) and amount n from 1 to 31, result is operand shifted left by n with zeros filled in, and the carry is operand bit 32-n.
- R2: With op_sel 1 (logical right) and n from 1 to 31, result is operand shifted right by n with zeros filled in, and the carry is operand bit n-1.
- R3: With op_sel 2 (arithmetic right) and n from 1 to 31, result is operand shifted right by n with copies of bit 31 filled in, and the carry is operand bit n-1.
- R4: With op_sel 3 (rotate right), the rotation uses amount modulo 32. For a nonzero remainder m, the result is operand rotated right by m and the carry equals result bit 31. If the amount is nonzero and a multiple of 32, the result equals operand and the carry is operand bit 31.
- R5: With op_sel 4 (rotate right by one through carry), the amount is ignored. The result is the operand shifted right by one with the incoming carry placed in bit 31, and the carry becomes operand bit 0.
- R6: For op_sel 0 to 3, amount 0 gives result equal to operand and carry equal to the incoming carry.
- R7: A logical shift by exactly 32 gives result 0. The carry is operand bit 0 for the left shift and operand bit 31 for the right shift.
- R8: A logical shift by 33 to 255 gives result 0 and carry 0.
- R9: An arithmetic right shift by 32 to 255 sets every result bit and the carry to operand bit 31.
- R10: When set_flags is 1, the negative flag is result bit 31, the zero flag is 1 exactly when the result is all zeros, and the carry flag is the computed carry. When set_flags is 0, the negative, zero and carry outputs equal their inputs.
- R11: The overflow output always equals the overflow input.
- R12: op_sel codes 5, 6 and 7 are reserved. They give result equal to operand and leave the carry equal to the incoming carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand | input | 32 | Value to shift or rotate |
| amount | input | 8 | Shift amount, 0 to 255 |
| op_sel | input | 3 | 0 LSL, 1 LSR, 2 ASR, 3 ROR, 4 rotate through carry, 5-7 reserved |
| set_flags | input | 1 | Enables update of N, Z and C |
| flag_n_in | input | 1 | Incoming negative flag |
| flag_z_in | input | 1 | Incoming zero flag |
| flag_c_in | input | 1 | Incoming carry flag, also shifted in by the one-place rotate |
| flag_v_in | input | 1 | Incoming overflow flag |
| result | output | 32 | Shifted or rotated value |
| flag_n_out | output | 1 | Outgoing negative flag |
| flag_z_out | output | 1 | Outgoing zero flag |
| flag_c_out | output | 1 | Outgoing carry flag |
| flag_v_out | output | 1 | Outgoing overflow flag |

## Verification
The result and all four flags are due in the same cycle the inputs change, because no register lies between any input and any output. The bench applies each vector one time unit after a rising edge and samples the outputs at the next falling edge, half a period later, so every path has settled. It sweeps all 256 amounts and all eight operation codes across a set of edge-case operands, both carry inputs and both flag-enable values. The expected values come from arithmetic using multiplication, division and remainder by powers of two.

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit (
  input  logic [31:0] operand,
  input  logic [7:0]  amount,
  input  logic [2:0]  op_sel,
  input  logic        set_flags,
  input  logic        flag_n_in,
  input  logic        flag_z_in,
  input  logic        flag_c_in,
  input  logic        flag_v_in,
  output logic [31:0] result,
  output logic        flag_n_out,
  output logic        flag_z_out,
  output logic        flag_c_out,
  output logic        flag_v_out
);
  localparam logic [2:0] OP_LSL = 3'd0;
  localparam logic [2:0] OP_LSR = 3'd1;
  localparam logic [2:0] OP_ASR = 3'd2;
  localparam logic [2:0] OP_ROR = 3'd3;
  localparam logic [2:0] OP_RRX = 3'd4;

  logic [4:0]  sh;
  logic        wide;
  logic        full;
  logic [4:0]  idx_left;
  logic [4:0]  idx_right;
  logic [31:0] rot;
  logic [31:0] asr_val;
  logic        carry;

  assign sh        = amount[4:0];
  assign wide      = |amount[7:5];
  assign full      = (amount == 8'd32);
  assign idx_left  = 5'(6'd32 - {1'b0, sh});
  assign idx_right = sh - 5'd1;
  assign rot       = (operand >> sh) | (operand << (6'd32 - {1'b0, sh}));
  assign asr_val   = $unsigned($signed(operand) >>> sh);

  always_comb begin
    result = operand;
    carry  = flag_c_in;
    case (op_sel)
      OP_LSL: if (amount != 8'd0) begin
        if (!wide) begin
          result = operand << sh;
          carry  = operand[idx_left];
        end else begin
          result = '0;
          carry  = full ? operand[0] : 1'b0;
        end
      end
      OP_LSR: if (amount != 8'd0) begin
        if (!wide) begin
          result = operand >> sh;
          carry  = operand[idx_right];
        end else begin
          result = '0;
          carry  = full ? operand[31] : 1'b0;
        end
      end
      OP_ASR: if (amount != 8'd0) begin
        if (!wide) begin
          result = asr_val;
          carry  = operand[idx_right];
        end else begin
          result = {32{operand[31]}};
          carry  = operand[31];
        end
      end
      OP_ROR: if (amount != 8'd0) begin
        if (sh == 5'd0) begin
          carry = operand[31];
        end else begin
          result = rot;
          carry  = rot[31];
        end
      end
      OP_RRX: begin
        result = {flag_c_in, operand[31:1]};
        carry  = operand[0];
      end
      default: ;
    endcase
  end

  assign flag_n_out = set_flags ? result[31]      : flag_n_in;
  assign flag_z_out = set_flags ? (result == '0)  : flag_z_in;
  assign flag_c_out = set_flags ? carry           : flag_c_in;
  assign flag_v_out = flag_v_in;

  always_comb begin
    if (set_flags)
      assert_zero_flag_R10: assert (flag_z_out == (result == 32'd0));
    if (!set_flags)
      assert_flags_hold_R10: assert (flag_n_out == flag_n_in && flag_c_out == flag_c_in);
    if (amount == 8'd0 && op_sel < OP_RRX)
      assert_zero_amount_R6: assert (result == operand);
    if (op_sel == OP_RRX)
      assert_rrx_top_bit_R5: assert (result[31] == flag_c_in && result[30:0] == operand[31:1]);
    if ((op_sel == OP_LSL || op_sel == OP_LSR) && amount > 8'd32)
      assert_long_shift_zero_R8: assert (result == 32'd0 && (!set_flags || !flag_c_out));
    if (op_sel == OP_ASR && amount >= 8'd32)
      assert_sign_fill_R9: assert (result == {32{operand[31]}});
    assert_overflow_kept_R11: assert (flag_v_out == flag_v_in);
  end
endmodule

// File: tb/shift_rotate_unit_test.sv
module shift_rotate_unit_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [31:0] operand;
  logic [7:0]  amount;
  logic [2:0]  op_sel;
  logic        set_flags, n_in, z_in, c_in, v_in;
  logic [31:0] result;
  logic        n_out, z_out, c_out, v_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  shift_rotate_unit uut (
    .operand(operand), .amount(amount), .op_sel(op_sel), .set_flags(set_flags),
    .flag_n_in(n_in), .flag_z_in(z_in), .flag_c_in(c_in), .flag_v_in(v_in),
    .result(result), .flag_n_out(n_out), .flag_z_out(z_out),
    .flag_c_out(c_out), .flag_v_out(v_out));

  function automatic logic [32:0] model(logic [2:0] o, logic [31:0] a, int n, logic ci);
    logic [63:0] x = {32'd0, a};
    logic [63:0] p;
    logic [63:0] q;
    int m;
    if (o == 3'd4) begin
      p = x / 64'd2 + (ci ? 64'h8000_0000 : 64'd0);
      return {a[0], p[31:0]};
    end
    if (o > 3'd4 || n == 0) return {ci, a};
    case (o)
      3'd0: begin
        if (n < 32) begin p = x * (64'd1 << n); return {p[32], p[31:0]}; end
        if (n == 32) return {a[0], 32'd0};
        return 33'd0;
      end
      3'd1: begin
        if (n < 32) begin
          p = x / (64'd1 << n); q = x / (64'd1 << (n - 1));
          return {q[0], p[31:0]};
        end
        if (n == 32) return {a[31], 32'd0};
        return 33'd0;
      end
      3'd2: begin
        if (n < 32) begin
          if (a[31]) p = ~(((~x) & 64'hFFFF_FFFF) / (64'd1 << n));
          else       p = x / (64'd1 << n);
          q = x / (64'd1 << (n - 1));
          return {q[0], p[31:0]};
        end
        return {a[31], {32{a[31]}}};
      end
      default: begin
        m = n % 32;
        if (m == 0) return {a[31], a};
        p = x / (64'd1 << m) + (x % (64'd1 << m)) * (64'd1 << (32 - m));
        return {p[31], p[31:0]};
      end
    endcase
  endfunction

  function automatic string tag_of(logic [2:0] o, int n);
    if (o > 3'd4) return "R12";
    if (o == 3'd4) return "R5";
    if (n == 0) return "R6";
    if (o == 3'd3) return "R4";
    if (o == 3'd2) return (n >= 32) ? "R9" : "R3";
    if (n == 32) return "R7";
    if (n > 32) return "R8";
    return (o == 3'd0) ? "R1" : "R2";
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h (op %0d amt %0d opnd %h)",
               req, what, act, exp, op_sel, amount, operand);
    end
  endtask

  task automatic run_vec(logic [31:0] a, int n, logic [2:0] o, logic ci, logic sf, logic vi);
    logic [32:0] m;
    string t;
    @(posedge clk);
    #1;
    operand = a; amount = 8'(n); op_sel = o; c_in = ci; set_flags = sf;
    n_in = ~ci; z_in = ci; v_in = vi;
    m = model(o, a, n, ci);
    t = tag_of(o, n);
    @(negedge clk);
    check(t, result, m[31:0], "result");
    if (sf) begin
      check(t, {31'd0, c_out}, {31'd0, m[32]}, "carry");
      check("R10", {31'd0, n_out}, {31'd0, m[31]}, "neg");
      check("R10", {31'd0, z_out}, {31'd0, m[31:0] == 32'd0}, "zero");
    end else begin
      check("R10", {29'd0, n_out, z_out, c_out}, {29'd0, ~ci, ci, ci}, "held flags");
    end
    check("R11", {31'd0, v_out}, {31'd0, vi}, "overflow");
  endtask

  localparam int NPAT = 7;
  logic [31:0] pats [NPAT] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h8000_0001,
                               32'h7FFF_FFFE, 32'hA5C3_0F96, 32'h0000_0001, 32'h8000_0000};

  initial begin
    operand = '0; amount = '0; op_sel = '0; set_flags = 1'b0;
    n_in = 1'b0; z_in = 1'b0; c_in = 1'b0; v_in = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R6", result, 32'd0, "reset-state result");
    check("R10", {28'd0, n_out, z_out, c_out, v_out}, 32'd0, "reset-state flags");
    for (int p = 0; p < NPAT; p++)
      for (int o = 0; o < 8; o++)
        for (int n = 0; n < 256; n++)
          for (int k = 0; k < 4; k++)
            run_vec(pats[p], n, 3'(o), k[0], k[1], k[0] ^ p[0]);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule